// File: doc/BRIEF.md
# Nested two-stage page walker

This block turns a guest-virtual address into a host-physical address by walking two page tables, one inside the other. The guest table is two levels deep and lives in guest-physical memory. Every guest-physical address the walk produces goes through a full walk of the two-level host table before it is used: the guest root pointer, the pointer to the guest second-level table, and the final guest-physical page. A walk with no cache hits therefore issues up to eight memory reads, where a single-stage walk issues two.

A requester hands over one address at a time with a valid/ready handshake, along with the current privilege mode. The walker reads table entries over a simple one-outstanding memory read port. It returns the host-physical address, or a fault that names the stage and level where an entry was absent. It also returns an execute-permission bit, taken from one of two separate bits in the guest leaf entry according to the mode. A small fully associative cache keeps recent guest-page to host-frame results, so that repeated guest pointers skip their host walks. A host first-level entry can map a 4 MB region directly.

Top module: `nest_walker`

## Requirements
- R1: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle. `busy` stays high from the cycle after acceptance until `done` rises. `done` is high for exactly one cycle, and the result outputs keep their values after it until the next result.
- R2: A table entry is 32 bits: bit 0 present, bit 1 large, bit 2 user execute, bit 3 supervisor execute, bits [31:12] frame number. The first-level index is address bits [31:22] and the second-level index is bits [21:12]. Entries are 4 bytes apart from the table base. The large bit is honoured only in host first-level entries and is ignored in guest entries.
- R3: The guest root entry address, the guest second-level table entry address and the final guest-physical address are each translated through the host table before use. The result is the host frame joined with guest-virtual bits [11:0].
- R4: A present host first-level entry with the large bit set ends that host walk after one read. The host address is entry bits [31:22] joined with guest-physical bits [21:0].
- R5: An absent entry stops the walk with `rsp_fault`=1. `rsp_fault_host` is 1 for a host table and 0 for the guest table. `rsp_fault_lvl` is 0 for the first level and 1 for the second. A faulting result has `rsp_hpa`=0 and `rsp_exec`=0.
- R6: For a successful walk, `rsp_exec` equals bit 2 of the guest leaf entry when `req_user`=1, and bit 3 when `req_user`=0.
- R7: A 4-entry fully associative cache maps a guest-physical page to a host frame and is filled after each successful host walk. A hit costs no memory read. With an empty cache, a walk through small host pages costs 8 reads, and repeating it costs 2.
- R8: Fills go to slots 0,1,2,3,0,... in turn, regardless of use. From an empty cache, walk A then A then walk C (which shares only A's root page) costs 8, 2, 6 reads. A following walk A costs 8.
- R9: A `flush` pulse empties the cache and restarts the fill order at slot 0. The next walk pays every host read again.
- R10: `mem_req_valid` is a one-cycle pulse with at most one read outstanding. The walker waits for `mem_rsp_valid` before it uses `mem_rsp_data`.
- R11: After reset the walker is idle: `req_ready`=1, `busy`=0, `done`=0, `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the host translation cache |
| guest_root | input | 32 | Guest-physical base of the guest first-level table |
| host_root | input | 32 | Host-physical base of the host first-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_gva | input | 32 | Guest-virtual address to translate |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_hpa | output | 32 | Host-physical result, 0 on fault |
| rsp_fault | output | 1 | Walk stopped on an absent entry |
| rsp_fault_host | output | 1 | Fault stage: 1 host, 0 guest |
| rsp_fault_lvl | output | 1 | Fault level: 0 first, 1 second |
| rsp_exec | output | 1 | Execute allowed in the requested mode |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | 32 | Host-physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
The bench targets faults in each of the four places: guest first and second level, and host first and second level. It also covers a host fault raised while translating a guest pointer rather than the final page. A walker that mixed up stage or level, or that went on reading after an absent entry, would return a wrong fault code or a stray address. Exact read counts across a hand-computed sequence catch caches that never hit, hit wrongly after a flush, or replace by recency instead of in turn. Large host regions and leaves executable in only one mode expose a walker that ignores the large bit or picks the wrong execute bit.

// File: rtl/nest_walker_pkg.sv
package nest_walker_pkg;
  // entry flag positions
  localparam int ENT_PRESENT = 0;
  localparam int ENT_LARGE   = 1;
  localparam int ENT_UX      = 2;
  localparam int ENT_SX      = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_HW1,
    ST_HW2,
    ST_GISSUE,
    ST_GW
  } walk_st_e;
endpackage

// File: rtl/nest_walker_cache.sv
module nest_walker_cache #(
  parameter int KEY_W = 20,
  parameter int VAL_W = 20,
  parameter int N     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic [VAL_W-1:0] lk_val,
  input  logic             fill_en,
  input  logic [KEY_W-1:0] fill_key,
  input  logic [VAL_W-1:0] fill_val
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld;
  logic [KEY_W-1:0] key_q [N];
  logic [VAL_W-1:0] val_q [N];
  logic [PTR_W-1:0] rr;
  logic [N-1:0]     match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g] = vld[g] && (key_q[g] == lk_key);
    end
  endgenerate

  assign lk_hit = |match;

  always_comb begin
    lk_val = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) lk_val = lk_val | val_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      rr  <= '0;
    end else if (fill_en) begin
      vld[rr] <= 1'b1;
      rr      <= (rr == PTR_W'(N - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      key_q[rr] <= fill_key;
      val_q[rr] <= fill_val;
    end
  end

  // R7
  key_unique_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
endmodule

// File: rtl/nest_walker_xsel.sv
module nest_walker_xsel (
  input  logic user,
  input  logic ux,
  input  logic sx,
  output logic allow
);
  assign allow = user ? ux : sx;
endmodule

// File: rtl/nest_walker.sv
module nest_walker
  import nest_walker_pkg::*;
#(
  parameter int AW      = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10,
  parameter int CACHE_N = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] guest_root,
  input  logic [AW-1:0] host_root,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_gva,
  input  logic          req_user,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] rsp_hpa,
  output logic          rsp_fault,
  output logic          rsp_fault_host,
  output logic          rsp_fault_lvl,
  output logic          rsp_exec,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);
  localparam int FRAME_W = AW - OFF_W;
  localparam int LARGE_W = OFF_W + IDX_W;

  walk_st_e            state;
  logic [LARGE_W-1:0]  gva_lo;
  logic [AW-1:0]       gpa_r, hpa_r;
  logic [1:0]          phase;
  logic                user_r, ux_r, sx_r;
  logic                exec_allow;
  logic                hit;
  logic [FRAME_W-1:0]  hit_frame;
  logic                fill_en;
  logic [FRAME_W-1:0]  fill_frame;
  logic [AW-1:0]       ent;
  logic                unused_bits;

  assign ent         = mem_rsp_data;
  assign unused_bits = ^ent[OFF_W-1:4];
  assign req_ready   = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);

  function automatic logic [AW-1:0] idx_off(input logic [IDX_W-1:0] idx);
    return AW'({idx, 2'b00});
  endfunction

  function automatic logic [AW-1:0] frame_base(input logic [AW-1:0] e);
    return {e[AW-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // cache fill after a successful host walk
  always_comb begin
    fill_en    = 1'b0;
    fill_frame = ent[AW-1:OFF_W];
    if (mem_rsp_valid && ent[ENT_PRESENT]) begin
      if (state == ST_HW1 && ent[ENT_LARGE]) begin
        fill_en    = 1'b1;
        fill_frame = {ent[AW-1:LARGE_W], gpa_r[LARGE_W-1:OFF_W]};
      end else if (state == ST_HW2) begin
        fill_en    = 1'b1;
      end
    end
  end

  nest_walker_cache #(.KEY_W(FRAME_W), .VAL_W(FRAME_W), .N(CACHE_N)) u_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_key(gpa_r[AW-1:OFF_W]), .lk_hit(hit), .lk_val(hit_frame),
    .fill_en(fill_en), .fill_key(gpa_r[AW-1:OFF_W]), .fill_val(fill_frame)
  );

  nest_walker_xsel u_xsel (.user(user_r), .ux(ux_r), .sx(sx_r), .allow(exec_allow));

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      gva_lo         <= '0;
      gpa_r          <= '0;
      hpa_r          <= '0;
      phase          <= '0;
      user_r         <= 1'b0;
      ux_r           <= 1'b0;
      sx_r           <= 1'b0;
      done           <= 1'b0;
      rsp_hpa        <= '0;
      rsp_fault      <= 1'b0;
      rsp_fault_host <= 1'b0;
      rsp_fault_lvl  <= 1'b0;
      rsp_exec       <= 1'b0;
      mem_req_valid  <= 1'b0;
      mem_req_addr   <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      done          <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          gva_lo <= req_gva[LARGE_W-1:0];
          user_r <= req_user;
          gpa_r  <= guest_root + idx_off(req_gva[AW-1 -: IDX_W]);
          phase  <= 2'd0;
          state  <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          hpa_r <= {hit_frame, gpa_r[OFF_W-1:0]};
          state <= ST_GISSUE;
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= host_root + idx_off(gpa_r[AW-1 -: IDX_W]);
          state         <= ST_HW1;
        end
        ST_HW1: if (mem_rsp_valid) begin
          if (!ent[ENT_PRESENT]) begin
            done <= 1'b1; rsp_fault <= 1'b1; rsp_fault_host <= 1'b1;
            rsp_fault_lvl <= 1'b0; rsp_hpa <= '0; rsp_exec <= 1'b0;
            state <= ST_IDLE;
          end else if (ent[ENT_LARGE]) begin
            hpa_r <= {ent[AW-1:LARGE_W], gpa_r[LARGE_W-1:0]};
            state <= ST_GISSUE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= frame_base(ent) + idx_off(gpa_r[LARGE_W-1 -: IDX_W]);
            state         <= ST_HW2;
          end
        end
        ST_HW2: if (mem_rsp_valid) begin
          if (!ent[ENT_PRESENT]) begin
            done <= 1'b1; rsp_fault <= 1'b1; rsp_fault_host <= 1'b1;
            rsp_fault_lvl <= 1'b1; rsp_hpa <= '0; rsp_exec <= 1'b0;
            state <= ST_IDLE;
          end else begin
            hpa_r <= {ent[AW-1:OFF_W], gpa_r[OFF_W-1:0]};
            state <= ST_GISSUE;
          end
        end
        ST_GISSUE: if (phase == 2'd2) begin
          done <= 1'b1; rsp_fault <= 1'b0; rsp_fault_host <= 1'b0;
          rsp_fault_lvl <= 1'b0; rsp_hpa <= hpa_r; rsp_exec <= exec_allow;
          state <= ST_IDLE;
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= hpa_r;
          state         <= ST_GW;
        end
        ST_GW: if (mem_rsp_valid) begin
          if (!ent[ENT_PRESENT]) begin
            done <= 1'b1; rsp_fault <= 1'b1; rsp_fault_host <= 1'b0;
            rsp_fault_lvl <= phase[0]; rsp_hpa <= '0; rsp_exec <= 1'b0;
            state <= ST_IDLE;
          end else if (phase == 2'd0) begin
            gpa_r <= frame_base(ent) + idx_off(gva_lo[LARGE_W-1 -: IDX_W]);
            phase <= 2'd1;
            state <= ST_LOOK;
          end else begin
            ux_r  <= ent[ENT_UX];
            sx_r  <= ent[ENT_SX];
            gpa_r <= {ent[AW-1:OFF_W], gva_lo[OFF_W-1:0]};
            phase <= 2'd2;
            state <= ST_LOOK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  req_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && !done));
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> (req_ready && !busy));
  // R10
  mem_single_chk: assert property (@(posedge clk) disable iff (rst) mem_req_valid |=> !mem_req_valid);
  // R10
  mem_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_req_valid |-> busy);
  // R5
  fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_fault) |-> (rsp_hpa == '0 && !rsp_exec));
endmodule

// File: tb/nest_walker_bench.sv
module nest_walker_bench;
  localparam bit [31:0] HROOT = 32'h0010_0000;
  localparam bit [31:0] GROOT = 32'h0000_1000;

  logic clk = 0, rst = 1, flush = 0;
  logic req_valid = 0, req_user = 0;
  logic [31:0] req_gva = 0;
  logic req_ready, busy, done, rsp_fault, rsp_fault_host, rsp_fault_lvl, rsp_exec;
  logic [31:0] rsp_hpa, mem_req_addr;
  logic mem_req_valid;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  bit [31:0] mem [bit [31:0]];
  int rd_cnt = 0, dbl_req = 0;
  int errors = 0, checks = 0;
  logic prev_req = 0;
  logic mid_busy, mid_ready, done_after, held;

  always #4 clk = ~clk;

  nest_walker u_nest_walker (
    .clk(clk), .rst(rst), .flush(flush), .guest_root(GROOT), .host_root(HROOT),
    .req_valid(req_valid), .req_ready(req_ready), .req_gva(req_gva), .req_user(req_user),
    .busy(busy), .done(done), .rsp_hpa(rsp_hpa), .rsp_fault(rsp_fault),
    .rsp_fault_host(rsp_fault_host), .rsp_fault_lvl(rsp_fault_lvl), .rsp_exec(rsp_exec),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic bit [31:0] rd(input bit [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid;
    mem_rsp_data  <= rd(mem_req_addr);
    if (mem_req_valid) rd_cnt <= rd_cnt + 1;
  end

  always @(negedge clk) begin
    if (!rst && prev_req && mem_req_valid) dbl_req <= dbl_req + 1;
    prev_req <= mem_req_valid;
  end

  function automatic void host_ref(input bit [31:0] gpa, output bit ok,
                                   output bit [31:0] hpa, output bit lv);
    bit [31:0] e1, e2;
    ok = 0; lv = 0; hpa = 0;
    e1 = rd(HROOT + {gpa[31:22], 2'b00});
    if (!e1[0]) return;
    if (e1[1]) begin ok = 1; hpa = {e1[31:22], gpa[21:0]}; return; end
    e2 = rd({e1[31:12], 12'h0} + {gpa[21:12], 2'b00});
    lv = 1;
    if (!e2[0]) return;
    ok = 1; hpa = {e2[31:12], gpa[11:0]};
  endfunction

  function automatic bit [35:0] ref_walk(input bit [31:0] gva, input bit usr);
    bit ok, lv; bit [31:0] h, e;
    host_ref(GROOT + {gva[31:22], 2'b00}, ok, h, lv);
    if (!ok) return {2'b11, lv, 1'b0, 32'h0};
    e = rd(h);
    if (!e[0]) return {4'b1000, 32'h0};
    host_ref({e[31:12], 12'h0} + {gva[21:12], 2'b00}, ok, h, lv);
    if (!ok) return {2'b11, lv, 1'b0, 32'h0};
    e = rd(h);
    if (!e[0]) return {4'b1010, 32'h0};
    host_ref({e[31:12], gva[11:0]}, ok, h, lv);
    if (!ok) return {2'b11, lv, 1'b0, 32'h0};
    return {3'b000, (usr ? e[2] : e[3]), h};
  endfunction

  task automatic gwrite(input bit [31:0] gpa, input bit [31:0] d);
    bit ok, lv; bit [31:0] h;
    host_ref(gpa, ok, h, lv);
    if (ok) mem[h] = d;
  endtask

  task automatic check(input string req, input bit [63:0] act, input bit [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] mk_gva(input int j, input int k, input int off);
    return {j[9:0], k[9:0], off[11:0]};
  endfunction

  task automatic walk(input bit [31:0] gva, input bit usr, output bit [35:0] res, output int reads);
    int start, n;
    bit [35:0] snap;
    start = rd_cnt;
    @(negedge clk);
    req_valid = 1; req_gva = gva; req_user = usr;
    @(negedge clk);
    req_valid = 0;
    mid_busy = busy; mid_ready = req_ready;
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) begin checks++; errors++; $display("FAIL R1 no done actual=0 expected=1"); end
    res = {rsp_fault, rsp_fault_host, rsp_fault_lvl, rsp_exec, rsp_hpa};
    reads = rd_cnt - start;
    snap = res;
    @(negedge clk);
    done_after = done;
    held = ({rsp_fault, rsp_fault_host, rsp_fault_lvl, rsp_exec, rsp_hpa} == snap);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [35:0] res;
    int reads;
    bit [31:0] gva, tgt;
    bit usr;
    void'($urandom(32'd2024));
    // host tables
    mem[HROOT + 0]  = 32'h0011_0001;
    mem[HROOT + 4]  = 32'h0800_0003;
    mem[HROOT + 12] = 32'h0012_0001;
    for (int i = 0; i < 1024; i++) begin
      mem[32'h0011_0000 + 4*i] = ((32'h400 + i) << 12) | 1;
      if (i % 2 == 0) mem[32'h0012_0000 + 4*i] = ((32'hC00 + i) << 12) | 1;
    end
    // guest tables
    for (int j = 0; j < 8; j++) gwrite(GROOT + 4*j, ((2 + j) << 12) | 1);
    gwrite(GROOT + 36, 32'h0080_0001);
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 1024; k++) begin
        if (k % 7 == 3) continue;
        case (k % 4)
          0: tgt = k << 12;
          1: tgt = 32'h0040_0000 + ((k + j) << 12);
          2: tgt = 32'h0080_0000 + (k << 12);
          default: tgt = 32'h00C0_0000 + ((k >> 1) << 12);
        endcase
        gwrite(((2 + j) << 12) + 4*k, tgt | (k[6] << 1) | (k[4] << 2) | (k[5] << 3) | 1);
      end

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check("R11 ready", req_ready, 1);
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 mem_req_valid", mem_req_valid, 0);

    do_flush();
    gva = mk_gva(0, 0, 'h123);
    walk(gva, 1, res, reads);
    check("R3 nested result", res, {4'b0000, 32'h0040_0123});
    check("R7 cold reads", reads, 8);
    check("R1 busy during walk", mid_busy, 1);
    check("R1 ready during walk", mid_ready, 0);
    check("R1 done one cycle", done_after, 0);
    check("R1 result held", held, 1);
    walk(gva, 1, res, reads);
    check("R7 warm reads", reads, 2);
    check("R7 warm result", res, {4'b0000, 32'h0040_0123});
    walk(mk_gva(1, 4, 0), 0, res, reads);
    check("R8 walk C reads", reads, 6);
    walk(gva, 1, res, reads);
    check("R8 round-robin eviction reads", reads, 8);
    do_flush();
    walk(gva, 1, res, reads);
    check("R9 after flush reads", reads, 8);

    // R4 host large region
    do_flush();
    walk(mk_gva(0, 1, 'hABC), 1, res, reads);
    check("R4 large reads", reads, 7);
    check("R4 large address", res[31:0], 32'h0800_0000 + (1 << 12) + 'hABC);

    // R6 split execute bits
    walk(mk_gva(0, 16, 0), 1, res, reads);
    check("R6 user exec bit2", res[32], 1);
    walk(mk_gva(0, 16, 0), 0, res, reads);
    check("R6 sup exec bit3", res[32], 0);
    walk(mk_gva(0, 32, 0), 0, res, reads);
    check("R6 sup exec set", res[32], 1);
    walk(mk_gva(0, 32, 0), 1, res, reads);
    check("R6 user exec clear", res[32], 0);
    // R2 guest large bit ignored (k=64 has bit1 set)
    walk(mk_gva(0, 64, 'h10), 1, res, reads);
    check("R2 guest large ignored", res, {4'b0000, 32'h0040_0000 + (64 << 12) + 'h10});

    // R5 faults
    walk(mk_gva(8, 0, 0), 1, res, reads);
    check("R5 guest L1 fault", res, {4'b1000, 32'h0});
    walk(mk_gva(0, 3, 0), 1, res, reads);
    check("R5 guest L2 fault", res, {4'b1010, 32'h0});
    walk(mk_gva(0, 2, 0), 1, res, reads);
    check("R5 host L1 fault on final", res, {4'b1100, 32'h0});
    walk(mk_gva(0, 7, 0), 1, res, reads);
    check("R5 host L2 fault", res, {4'b1110, 32'h0});
    walk(mk_gva(9, 0, 0), 1, res, reads);
    check("R5 host fault on pointer", res, {4'b1100, 32'h0});

    // random mix
    for (int n = 0; n < 200; n++) begin
      gva = mk_gva($urandom_range(0, 9), $urandom_range(0, 1023), $urandom_range(0, 4095));
      usr = $urandom_range(0, 1);
      if (n % 50 == 0) do_flush();
      walk(gva, usr, res, reads);
      check("R3 R5 R6 random walk", res, ref_walk(gva, usr));
    end

    check("R10 single outstanding", dbl_req, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule